// File: doc/BRIEF.md
# Stacked Interrupt Status Controller

This block gathers interrupt conditions from two groups of sources, a bus-side group of sixteen conditions and a DMA-side group of eight. It keeps them in read-to-clear status registers and drives one active-low interrupt pin. The bus-side status is stacked one entry deep. A condition that fires while an earlier one is still being reported waits in a second copy and is presented after software clears the first. Nothing is merged into the reported copy and nothing is lost.

Software sees the block through a small register port with eight byte addresses. The port gives a summary byte holding the two pending bits and a pin-mask bit, the two bus-side status bytes, the DMA status byte, per-condition enable bytes, and an auxiliary byte holding a CRC-error flag. Enables decide only whether a recorded condition counts as pending and reaches the pin. Software is expected to read the bus-side bytes before the DMA byte.

Top module: `irq_stack_ctrl`

## Requirements
- R1: After reset every status byte, enable byte, the mask bit and the CRC flag read 0, and `irq_n` is 1.
- R2: A pulse on `bus_evt_i[k]` sets bit k of the bus status word (address 1 holds bits 7:0, address 2 holds bits 15:8) whether or not enable bit k is set. A disabled condition sets neither the bus pending bit nor the pin.
- R3: Summary byte (address 0): bit 0 is set when any bus status bit is set together with its enable bit (address 3 low, address 4 high), bit 1 is set when any DMA status bit is set together with its enable bit (address 6), and bit 2 is the mask bit. `irq_n` is low when bit 1 is set, or when bit 0 is set and not masked.
- R4: A read of address 2 clears both bus status bytes from the next cycle onward. A read of address 1 alone clears nothing.
- R5: A bus event that arrives while the reported bus word is nonzero is queued in a single stacked entry. Further events OR into that entry. The read of address 2 then presents the stacked entry, so the status can be nonzero straight after the read.
- R6: A bus event in the same cycle as a clearing read of address 2 is never dropped. It becomes the reported word if the stack was empty, and otherwise the new stacked entry.
- R7: The DMA status byte (address 5) records `dma_evt_i` and is cleared by its own read. An event in the same cycle as that read survives. Bus and DMA pending bits can be set together.
- R8: While the mask bit is 1, bus pending does not drive `irq_n` low, but the status and bus pending bit are still set.
- R9: If `irq_n` is low because of bus pending when the mask bit is written to 1, it stays low until the read of address 2 (or until bus pending drops). After that, bus interrupts stay masked.
- R10: Address 7 bit 7 is a CRC-error flag. A pulse on `crc_err_i` sets it, and a read of address 2 clears it. A set in the same cycle as that read wins.
- R11: Reading the DMA byte or any enable/summary address does not change the bus status, and reading the bus bytes does not change the DMA byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_evt_i | input | 16 | Bus-side condition pulses, one per bit |
| dma_evt_i | input | 8 | DMA-side condition pulses |
| crc_err_i | input | 1 | CRC error pulse |
| rd_en | input | 1 | Read strobe, one cycle |
| wr_en | input | 1 | Write strobe, one cycle |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq_n | output | 1 | Active-low interrupt pin |

## Verification
The two functions that can fall in the same cycle are the clearing read of the bus status and the arrival of a new bus event. The same applies to the DMA read and a DMA event, and to the CRC clear and a CRC set. The bench provokes these collisions on purpose, with the stack both empty and occupied. It also runs a long stretch of random traffic where such overlaps occur by chance. A queue-based reference model judges each collision cycle by cycle from the requirements, and the pin and read data are compared on every clock.

// File: rtl/irq_stack_pkg.sv
// Shared address map and bit positions of the stacked interrupt controller.
// Assumes a byte-wide register port with eight locations.
package irq_stack_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_SUMMARY = 3'd0,
        A_BUS_LO  = 3'd1,
        A_BUS_HI  = 3'd2,
        A_BEN_LO  = 3'd3,
        A_BEN_HI  = 3'd4,
        A_DMA     = 3'd5,
        A_DEN     = 3'd6,
        A_AUX     = 3'd7
    } reg_addr_e;

    localparam int SUM_BUS_BIT  = 0;
    localparam int SUM_DMA_BIT  = 1;
    localparam int SUM_MASK_BIT = 2;
    localparam int AUX_CRC_BIT  = 7;
endpackage

// File: rtl/irq_stat_stack.sv
// One-deep stacked status word.
// live is the reported word, stk the queued entry, stk_v marks stk occupied.
// Assumes pop is a single-cycle strobe; the pop is visible the cycle after it.
module irq_stat_stack #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         pop,
    output logic [W-1:0] live,
    output logic [W-1:0] stk,
    output logic         stk_v
);
    logic live_busy;
    logic evt_any;

    // Occupancy of the reported word and presence of a new event.
    always_comb begin
        live_busy = |live;
        evt_any   = |evt;
    end

    // Pop, load or stack the incoming events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live  <= '0;
            stk   <= '0;
            stk_v <= 1'b0;
        end else if (pop) begin
            if (stk_v) begin
                live  <= stk;
                stk   <= evt;
                stk_v <= evt_any;
            end else begin
                live  <= evt;
                stk   <= '0;
                stk_v <= 1'b0;
            end
        end else if (!live_busy) begin
            live <= evt;
        end else if (evt_any) begin
            stk   <= stk | evt;
            stk_v <= 1'b1;
        end
    end
endmodule

// File: rtl/irq_pin_gate.sv
// Drives the active-low interrupt pin from the two pending bits.
// A mask set while bus pending is on the pin keeps that assertion held until
// the bus status is popped or pending drops; later bus interrupts stay masked.
module irq_pin_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_pend,
    input  logic dma_pend,
    input  logic mask,
    input  logic mask_set,
    input  logic bus_pop,
    output logic held,
    output logic irq_n
);
    logic bus_drive;

    // Bus side reaches the pin when unmasked or held over from before the mask.
    always_comb begin
        bus_drive = bus_pend && (!mask || held);
        irq_n     = !(bus_drive || dma_pend);
    end

    // Track an assertion that was on the pin when the mask went on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 1'b0;
        end else if (bus_pop || !bus_pend) begin
            held <= 1'b0;
        end else if (mask_set && !mask) begin
            held <= 1'b1;
        end
    end
endmodule

// File: rtl/irq_reg_port.sv
// Register port: enables, mask, CRC flag, read-to-clear strobes, read mux.
// Assumes single-cycle rd_en/wr_en strobes; rdata follows addr combinationally.
module irq_reg_port
    import irq_stack_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int NBYTE  = 2,
    localparam int BUS_W = BYTE_W * NBYTE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BUS_W-1:0]  bus_live,
    input  logic [BYTE_W-1:0] dma_st,
    input  logic              bus_pend,
    input  logic              dma_pend,
    input  logic              crc_err_i,
    output logic [BUS_W-1:0]  bus_en,
    output logic [BYTE_W-1:0] dma_en,
    output logic              mask,
    output logic              mask_set,
    output logic              bus_pop,
    output logic              dma_pop,
    output logic              crc_flag,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] bus_byte [NBYTE];
    logic [BYTE_W-1:0] ben_byte [NBYTE];

    // Slice the bus status and enables into bytes.
    for (genvar g = 0; g < NBYTE; g++) begin : g_bytes
        assign bus_byte[g] = bus_live[g*BYTE_W +: BYTE_W];
        assign ben_byte[g] = bus_en[g*BYTE_W +: BYTE_W];
    end

    // Decode the clearing reads and the mask-set write.
    always_comb begin
        bus_pop  = rd_en && (addr == A_BUS_HI);
        dma_pop  = rd_en && (addr == A_DMA);
        mask_set = wr_en && (addr == A_SUMMARY) && wdata[SUM_MASK_BIT];
    end

    // Writable enables and mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_en <= '0;
            dma_en <= '0;
            mask   <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                A_SUMMARY: mask <= wdata[SUM_MASK_BIT];
                A_BEN_LO:  bus_en[BYTE_W-1:0] <= wdata;
                A_BEN_HI:  bus_en[BUS_W-1:BYTE_W] <= wdata;
                A_DEN:     dma_en <= wdata;
                default:   ;
            endcase
        end
    end

    // CRC flag: set wins over the clear by the bus status pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_flag <= 1'b0;
        end else if (crc_err_i) begin
            crc_flag <= 1'b1;
        end else if (bus_pop) begin
            crc_flag <= 1'b0;
        end
    end

    // Read data multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            A_SUMMARY: begin
                rdata[SUM_BUS_BIT]  = bus_pend;
                rdata[SUM_DMA_BIT]  = dma_pend;
                rdata[SUM_MASK_BIT] = mask;
            end
            A_BUS_LO: rdata = bus_byte[0];
            A_BUS_HI: rdata = bus_byte[NBYTE-1];
            A_BEN_LO: rdata = ben_byte[0];
            A_BEN_HI: rdata = ben_byte[NBYTE-1];
            A_DMA:    rdata = dma_st;
            A_DEN:    rdata = dma_en;
            A_AUX:    rdata[AUX_CRC_BIT] = crc_flag;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_stack_ctrl.sv
// Top of the stacked interrupt status controller.
// Bus-side conditions go through a one-deep stack; DMA conditions accumulate
// in a read-to-clear byte. Assumes event inputs are synchronous pulses.
module irq_stack_ctrl
    import irq_stack_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int NBYTE = 2,
    localparam int BUS_W = BYTE_W * NBYTE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  bus_evt_i,
    input  logic [BYTE_W-1:0] dma_evt_i,
    input  logic              crc_err_i,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              irq_n
);
    logic [BUS_W-1:0]  bus_live;
    logic [BUS_W-1:0]  bus_stk;
    logic              bus_stk_v;
    logic [BUS_W-1:0]  bus_en;
    logic [BYTE_W-1:0] dma_st;
    logic [BYTE_W-1:0] dma_en;
    logic              bus_pend;
    logic              dma_pend;
    logic              mask;
    logic              mask_set;
    logic              bus_pop;
    logic              dma_pop;
    logic              crc_flag;
    logic              held;

    irq_stat_stack #(.W(BUS_W)) u_bus_stack (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (bus_evt_i),
        .pop   (bus_pop),
        .live  (bus_live),
        .stk   (bus_stk),
        .stk_v (bus_stk_v)
    );

    // DMA status byte: accumulate, reload with same-cycle events on read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_st <= '0;
        end else if (dma_pop) begin
            dma_st <= dma_evt_i;
        end else begin
            dma_st <= dma_st | dma_evt_i;
        end
    end

    // Enabled pending summaries.
    always_comb begin
        bus_pend = |(bus_live & bus_en);
        dma_pend = |(dma_st & dma_en);
    end

    irq_reg_port #(.BYTE_W(BYTE_W), .NBYTE(NBYTE)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .bus_live  (bus_live),
        .dma_st    (dma_st),
        .bus_pend  (bus_pend),
        .dma_pend  (dma_pend),
        .crc_err_i (crc_err_i),
        .bus_en    (bus_en),
        .dma_en    (dma_en),
        .mask      (mask),
        .mask_set  (mask_set),
        .bus_pop   (bus_pop),
        .dma_pop   (dma_pop),
        .crc_flag  (crc_flag),
        .rdata     (rdata)
    );

    irq_pin_gate u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_pend (bus_pend),
        .dma_pend (dma_pend),
        .mask     (mask),
        .mask_set (mask_set),
        .bus_pop  (bus_pop),
        .held     (held),
        .irq_n    (irq_n)
    );
endmodule

// File: rtl/irq_stack_ctrl_chk.sv
// Property checker for irq_stack_ctrl, attached by bind.
module irq_stack_ctrl_chk #(
    parameter int BYTE_W = 8,
    localparam int BUS_W = 2 * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [2:0]        addr,
    input logic [BUS_W-1:0]  bus_evt_i,
    input logic [BYTE_W-1:0] dma_evt_i,
    input logic              crc_err_i,
    input logic              irq_n,
    input logic [BUS_W-1:0]  bus_live,
    input logic [BUS_W-1:0]  bus_stk,
    input logic              bus_stk_v,
    input logic [BUS_W-1:0]  bus_en,
    input logic [BYTE_W-1:0] dma_st,
    input logic              dma_pend,
    input logic              mask,
    input logic              held,
    input logic              crc_flag
);
    AST_POP_STACKED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd2 && bus_stk_v) |=> bus_live == $past(bus_stk)); // R5
    AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd2 && !bus_stk_v) |=> bus_live == $past(bus_evt_i)); // R6
    AST_QUEUE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!(rd_en && addr == 3'd2) && bus_live != '0 && bus_evt_i != '0) |=> bus_stk_v); // R5
    AST_LO_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd1 && bus_evt_i == '0) |=> bus_live == $past(bus_live)); // R4
    AST_PIN_NEEDS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_live & bus_en) == '0 && !dma_pend) |-> irq_n); // R3
    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (mask && !held && !dma_pend) |-> irq_n); // R8
    AST_CRC_SET: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err_i |=> crc_flag); // R10
    AST_DMA_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 3'd5 && dma_evt_i == '0) |=> dma_st == '0); // R7
endmodule

bind irq_stack_ctrl irq_stack_ctrl_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .addr      (addr),
    .bus_evt_i (bus_evt_i),
    .dma_evt_i (dma_evt_i),
    .crc_err_i (crc_err_i),
    .irq_n     (irq_n),
    .bus_live  (bus_live),
    .bus_stk   (bus_stk),
    .bus_stk_v (bus_stk_v),
    .bus_en    (bus_en),
    .dma_st    (dma_st),
    .dma_pend  (dma_pend),
    .mask      (mask),
    .held      (held),
    .crc_flag  (crc_flag)
);

// File: tb/test_irq_stack_ctrl.sv
module test_irq_stack_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_evt = '0;
    logic [7:0]  dma_evt = '0;
    logic        crc_err = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq_n;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Reference model state
    bit [15:0] q[$];
    bit [7:0]  m_dma, m_ben_lo, m_ben_hi, m_den;
    bit        m_mask, m_held, m_crc;

    always #10 clk = ~clk;

    irq_stack_ctrl i_irq_stack_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_evt_i(bus_evt), .dma_evt_i(dma_evt),
        .crc_err_i(crc_err), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
    );

    function automatic bit [15:0] m_live();
        return (q.size() > 0) ? q[0] : 16'h0;
    endfunction

    function automatic bit m_bus_pend();
        return |(m_live() & {m_ben_hi, m_ben_lo});
    endfunction

    function automatic bit m_dma_pend();
        return |(m_dma & m_den);
    endfunction

    function automatic bit m_pin();
        return !((m_bus_pend() && (!m_mask || m_held)) || m_dma_pend());
    endfunction

    function automatic bit [7:0] m_read(input bit [2:0] a);
        bit [15:0] lv = m_live();
        case (a)
            3'd0: return {5'b0, m_mask, m_dma_pend(), m_bus_pend()};
            3'd1: return lv[7:0];
            3'd2: return lv[15:8];
            3'd3: return m_ben_lo;
            3'd4: return m_ben_hi;
            3'd5: return m_dma;
            3'd6: return m_den;
            default: return {m_crc, 7'b0};
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic m_reset();
        q.delete();
        m_dma = 0; m_ben_lo = 0; m_ben_hi = 0; m_den = 0;
        m_mask = 0; m_held = 0; m_crc = 0;
    endtask

    // Model update for one clock with the given inputs.
    task automatic m_clock(input bit [15:0] be, input bit [7:0] de, input bit c,
                           input bit r, input bit w, input bit [2:0] a, input bit [7:0] wd);
        bit pop = r && a == 3'd2;
        bit dpop = r && a == 3'd5;
        bit bp = m_bus_pend();
        bit nh;
        if (pop || !bp) nh = 0;
        else if (w && a == 3'd0 && wd[2] && !m_mask) nh = 1;
        else nh = m_held;
        m_held = nh;
        if (w) begin
            case (a)
                3'd0: m_mask = wd[2];
                3'd3: m_ben_lo = wd;
                3'd4: m_ben_hi = wd;
                3'd6: m_den = wd;
                default: ;
            endcase
        end
        if (c) m_crc = 1;
        else if (pop) m_crc = 0;
        m_dma = dpop ? de : (m_dma | de);
        if (pop && q.size() > 0) void'(q.pop_front());
        if (be != 0) begin
            if (q.size() < 2) q.push_back(be);
            else q[1] = q[1] | be;
        end
    endtask

    // One cycle: drive at negedge, compare, then advance the model.
    task automatic step(input string tag, input bit [15:0] be = 0, input bit [7:0] de = 0,
                        input bit c = 0, input bit r = 0, input bit w = 0,
                        input bit [2:0] a = 0, input bit [7:0] wd = 0);
        @(negedge clk);
        bus_evt = be; dma_evt = de; crc_err = c; rd_en = r; wr_en = w; addr = a; wdata = wd;
        #1;
        check({tag, " pin"}, {7'b0, irq_n}, {7'b0, m_pin()});
        if (r) check({tag, " rdata"}, rdata, m_read(a));
        m_clock(be, de, c, r, w, a, wd);
    endtask

    task automatic rd(input string tag, input bit [2:0] a);
        step(tag, 0, 0, 0, 1, 0, a, 0);
    endtask

    task automatic wr(input string tag, input bit [2:0] a, input bit [7:0] d);
        step(tag, 0, 0, 0, 0, 1, a, d);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values on all addresses
        for (int a = 0; a < 8; a++) rd("R1 reset", 3'(a));
        // R2: disabled condition recorded, no pending, no pin
        step("R2 evt", 16'h0081);
        rd("R2 lo", 3'd1); rd("R2 summary", 3'd0);
        // R4: low read keeps, high read clears
        rd("R4 lo keep", 3'd1); rd("R4 hi pop", 3'd2); rd("R4 after pop", 3'd1);
        // R3: enabled condition raises pending and pin
        wr("R3 ben", 3'd3, 8'h01); wr("R3 benh", 3'd4, 8'h80);
        step("R3 evt", 16'h0001); rd("R3 summary", 3'd0);
        // R5: stacking and OR into stacked entry
        step("R5 q1", 16'h0100); step("R5 q2", 16'h0200);
        rd("R5 lo", 3'd1); rd("R5 pop", 3'd2);
        rd("R5 next lo", 3'd1); rd("R5 next hi", 3'd2);
        // R6: event during pop, stack empty then occupied
        step("R6 evt", 16'h8000);
        step("R6 pop+evt", 16'h0004, 0, 0, 1, 0, 3'd2);
        rd("R6 lo", 3'd1);
        step("R6 stack", 16'h0010);
        step("R6 pop+evt2", 16'h0020, 0, 0, 1, 0, 3'd2);
        rd("R6 lo2", 3'd1); rd("R6 pop2", 3'd2); rd("R6 lo3", 3'd1); rd("R6 pop3", 3'd2);
        // R7: both pending, DMA read clear with same-cycle event
        wr("R7 den", 3'd6, 8'h03);
        step("R7 both", 16'h0001, 8'h01); rd("R7 summary", 3'd0);
        // R11: DMA read leaves bus alone
        step("R7 rd+evt", 0, 8'h02, 0, 1, 0, 3'd5);
        rd("R11 bus kept", 3'd1); rd("R7 dma", 3'd5); rd("R7 dma clr", 3'd5);
        rd("R11 pop", 3'd2); rd("R11 empty", 3'd1);
        // R8: mask blocks new bus interrupts but pending stays
        wr("R8 mask", 3'd0, 8'h04);
        step("R8 evt", 16'h0001); rd("R8 summary", 3'd0); rd("R8 pop", 3'd2);
        // R9: assertion held across mask set, dropped by pop
        wr("R9 unmask", 3'd0, 8'h00);
        step("R9 evt", 16'h8000);
        wr("R9 mask on", 3'd0, 8'h04);
        step("R9 held", 16'h0001); step("R9 held2");
        rd("R9 pop", 3'd2); step("R9 masked"); rd("R9 pop2", 3'd2);
        wr("R9 unmask", 3'd0, 8'h00);
        // R10: CRC flag
        step("R10 set", 0, 0, 1); rd("R10 flag", 3'd7);
        step("R10 set+pop", 0, 0, 1, 1, 0, 3'd2); rd("R10 stays", 3'd7);
        rd("R10 pop", 3'd2); rd("R10 clear", 3'd7);
        // Random traffic where collisions happen by chance (R5 R6 R7 R9 R10)
        for (int i = 0; i < 4000; i++) begin
            bit [15:0] be = ($urandom_range(0, 3) == 0) ? 16'(1 << $urandom_range(0, 15)) : 16'h0;
            bit [7:0]  de = ($urandom_range(0, 5) == 0) ? 8'(1 << $urandom_range(0, 7)) : 8'h0;
            bit c = ($urandom_range(0, 15) == 0);
            int k = $urandom_range(0, 9);
            if (k < 5) step("RND R6", be, de, c, 1, 0, 3'($urandom_range(0, 7)));
            else if (k < 7) step("RND R9", be, de, c, 0, 1, 3'($urandom_range(0, 7)), 8'($urandom));
            else step("RND R5", be, de, c);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule